// File: doc/BRIEF.md
# Escaped byte-stream ingress decoder

This block takes the byte stream coming out of a serial receiver and splits it into user data and in-band control. The link has no side-band control lines, so one byte value, 0xFE, acts as an escape. When the user's own data contains that value, the host sends it twice. An escape followed by any other byte opens a control datagram. The decoder understands three control datagrams. The first is a credit grant for the outbound direction, which is passed on as a one-cycle pulse together with a 14-bit value. The other two set the level of the user-logic reset output and of the link-reset output.

User bytes are handed to a downstream FIFO over a valid/ready pair through a one-byte holding register. The incoming stream cannot be stalled. While the FIFO refuses data, escape detection and command decoding carry on, so a reset command still gets through to a deadlocked design. A modulo counter of delivered bytes lets a credit manager work out how much inbound credit the host has used.

Top module: `esc_rx_decoder`

## Requirements
- R1: After reset, out_valid, credit_valid, logic_rst and comm_rst are 0 and data_count is 0.
- R2: In data mode, every received byte other than 0xFE is delivered on out_data, in arrival order. out_valid rises in the cycle after the byte is sampled.
- R3: The byte pair 0xFE 0xFE delivers exactly one 0xFE data byte.
- R4: The sequence 0xFE, {0, c[13:8], 1}, L makes credit_valid high for exactly one cycle, in the cycle after L is sampled, with credit_value = {c[13:8], L}. L is taken verbatim, even when it is 0xFE. No byte of the sequence is delivered as data.
- R5: The sequence 0xFE, 1000_00r1 sets logic_rst to r (0x81 gives 0, 0x83 gives 1). The level changes in the cycle after the command word and holds until the next such command.
- R6: The sequence 0xFE, 1000_01r1 sets comm_rst to r (0x85 gives 0, 0x87 gives 1). The level changes in the cycle after the command word and holds until the next such command.
- R7: A byte after 0xFE that is neither 0xFE nor one of the words in R4 to R6 (for example 0x80 or 0xF1) is discarded. It changes no output and produces no credit pulse, and the next byte is treated as data mode.
- R8: While out_valid is 1 and out_ready is 0, out_data stays stable and out_valid stays 1. Control datagrams received during that time still take effect.
- R9: A data byte that arrives while the holding register is full and out_ready is 0 is discarded.
- R10: data_count increments by one, modulo 2^CNT_W, on each cycle with out_valid and out_ready both high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_byte | input | 8 | Received byte |
| out_valid | output | 1 | Held user byte is available |
| out_data | output | 8 | Held user byte |
| out_ready | input | 1 | FIFO accepts the held byte |
| credit_valid | output | 1 | One-cycle outbound credit grant pulse |
| credit_value | output | CRED_W | Granted credit amount |
| logic_rst | output | 1 | User-logic reset level |
| comm_rst | output | 1 | Link-side reset level |
| data_count | output | CNT_W | Modulo count of delivered user bytes |

## Verification
Two functions can fall in the same cycle: a user-byte handoff to the FIFO, and the completion of a control datagram. The bench holds out_ready low so that a data byte waits in the register, then sends a credit grant or a reset command. It raises out_ready so that the handoff happens in the very cycle the credit pulse is visible. The scoreboard must see both the byte and the credit value, and data_count must advance by exactly one. The stalled case is also judged on its own: the reset levels must change while out_data stays frozen, and a second data byte sent into the full register must never appear.

// File: rtl/esc_rx_pkg.sv
package esc_rx_pkg;
    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_ESC  = 2'd1,
        ST_CRED = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        WK_CREDIT = 2'd0,
        WK_LRST   = 2'd1,
        WK_CRST   = 2'd2,
        WK_NONE   = 2'd3
    } word_kind_e;
endpackage

// File: rtl/esc_word_class.sv
module esc_word_class
    import esc_rx_pkg::*;
#(
    parameter int HI_W = 6
) (
    input  logic [7:0]  word,
    output word_kind_e  kind,
    output logic        level
);
    always_comb begin
        kind  = WK_NONE;
        level = word[1];
        if (word[0]) begin
            if (word[7:HI_W+1] == '0)
                kind = WK_CREDIT;
            else if (word[7:2] == 6'b100000)
                kind = WK_LRST;
            else if (word[7:2] == 6'b100001)
                kind = WK_CRST;
        end
    end
endmodule

// File: rtl/esc_skid.sv
module esc_skid #(
    parameter int DW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [DW-1:0]    out_data,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic             valid;
        logic [DW-1:0]    data;
        logic [CNT_W-1:0] count;
    } skid_t;

    skid_t skid_d, skid_q;

    always_comb begin
        skid_d = skid_q;
        if (skid_q.valid && out_ready) begin
            skid_d.valid = 1'b0;
            skid_d.count = skid_q.count + 1'b1;
        end
        if (push && (!skid_q.valid || out_ready)) begin
            skid_d.valid = 1'b1;
            skid_d.data  = push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) skid_q <= '0;
        else        skid_q <= skid_d;
    end

    assign out_valid = skid_q.valid;
    assign out_data  = skid_q.data;
    assign count     = skid_q.count;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=> (count == $past(count) + 1'b1)); // R10
    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_ready) |=> $stable(count)); // R10
endmodule

// File: rtl/esc_rx_decoder.sv
module esc_rx_decoder
    import esc_rx_pkg::*;
#(
    parameter logic [7:0] ESC_BYTE = 8'hFE,
    parameter int         CRED_W   = 14,
    parameter int         CNT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    output logic              out_valid,
    output logic [7:0]        out_data,
    input  logic              out_ready,
    output logic              credit_valid,
    output logic [CRED_W-1:0] credit_value,
    output logic              logic_rst,
    output logic              comm_rst,
    output logic [CNT_W-1:0]  data_count
);
    localparam int HI_W = CRED_W - 8;

    typedef struct packed {
        rx_state_e         state;
        logic [HI_W-1:0]   hi;
        logic              credit_valid;
        logic [CRED_W-1:0] credit_value;
        logic              logic_rst;
        logic              comm_rst;
    } dec_t;

    dec_t       dec_d, dec_q;
    word_kind_e kind;
    logic       level;
    logic       push;

    esc_word_class #(.HI_W(HI_W)) u_class (
        .word  (in_byte),
        .kind  (kind),
        .level (level)
    );

    always_comb begin
        dec_d              = dec_q;
        dec_d.credit_valid = 1'b0;
        push               = 1'b0;
        if (in_valid) begin
            unique case (dec_q.state)
                ST_DATA: begin
                    if (in_byte == ESC_BYTE) dec_d.state = ST_ESC;
                    else                     push = 1'b1;
                end
                ST_ESC: begin
                    dec_d.state = ST_DATA;
                    if (in_byte == ESC_BYTE) begin
                        push = 1'b1;
                    end else begin
                        case (kind)
                            WK_CREDIT: begin
                                dec_d.hi    = in_byte[HI_W:1];
                                dec_d.state = ST_CRED;
                            end
                            WK_LRST: dec_d.logic_rst = level;
                            WK_CRST: dec_d.comm_rst  = level;
                            default: ;
                        endcase
                    end
                end
                ST_CRED: begin
                    dec_d.credit_valid = 1'b1;
                    dec_d.credit_value = {dec_q.hi, in_byte};
                    dec_d.state        = ST_DATA;
                end
                default: dec_d.state = ST_DATA;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    esc_skid #(.DW(8), .CNT_W(CNT_W)) u_skid (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (in_byte),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .count     (data_count)
    );

    assign credit_valid = dec_q.credit_valid;
    assign credit_value = dec_q.credit_value;
    assign logic_rst    = dec_q.logic_rst;
    assign comm_rst     = dec_q.comm_rst;

    AST_CREDIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        credit_valid |=> !credit_valid); // R4
    AST_CREDIT_AFTER_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_q.state == ST_CRED) |=> credit_valid); // R4
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(logic_rst) && $stable(comm_rst))); // R5
    AST_NO_DATA_IN_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_q.state == ST_CRED && !out_valid) |=> !out_valid); // R4
endmodule

// File: tb/sim_esc_rx_decoder.sv
module sim_esc_rx_decoder;
    localparam int CNT_W = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b1;
    logic        credit_valid;
    logic [13:0] credit_value;
    logic        logic_rst;
    logic        comm_rst;
    logic [CNT_W-1:0] data_count;

    int checks = 0;
    int fails  = 0;
    int total  = 0;
    bit done   = 0;
    logic [7:0]  exp_data[$];
    logic [13:0] exp_cred[$];
    logic [CNT_W-1:0] cnt_before;

    always #2 clk = ~clk;

    esc_rx_decoder #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .credit_valid(credit_valid), .credit_value(credit_value),
        .logic_rst(logic_rst), .comm_rst(comm_rst), .data_count(data_count)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (exp_data.size() == 0) check(0, "R7 unexpected data byte", out_data, 0);
            else begin
                logic [7:0] e;
                e = exp_data.pop_front();
                check(out_data == e, "R2 data order", out_data, e);
            end
        end
        if (rst_n && credit_valid) begin
            if (exp_cred.size() == 0) check(0, "R7 unexpected credit", credit_value, 0);
            else begin
                logic [13:0] c;
                c = exp_cred.pop_front();
                check(credit_value == c, "R4 credit value", credit_value, c);
            end
        end
    end

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic send_data(input logic [7:0] b);
        exp_data.push_back(b);
        total++;
        if (b == 8'hFE) send(8'hFE);
        send(b);
    endtask

    task automatic send_credit(input logic [13:0] c);
        exp_cred.push_back(c);
        send(8'hFE);
        send({1'b0, c[13:8], 1'b1});
        send(c[7:0]);
    endtask

    task automatic drain;
        for (int i = 0; i < 50 && (exp_data.size() != 0 || exp_cred.size() != 0); i++)
            @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check(out_valid == 0, "R1 out_valid", out_valid, 0);
        check(credit_valid == 0, "R1 credit_valid", credit_valid, 0);
        check(logic_rst == 0, "R1 logic_rst", logic_rst, 0);
        check(comm_rst == 0, "R1 comm_rst", comm_rst, 0);
        check(data_count == 0, "R1 data_count", data_count, 0);
        rst_n = 1'b1;

        // R2 plain bytes
        send_data(8'h12); send_data(8'h00); send_data(8'hFF); send_data(8'hAF);
        // R3 doubled escape
        send_data(8'hFE); send_data(8'h34);
        // R4 credit grants, including escape value as low byte
        send_credit(14'h1234);
        send_credit(14'h3FFE);
        send_data(8'h56);
        drain();

        // R5 logic reset commands
        send(8'hFE); send(8'h83);
        check(logic_rst == 1, "R5 logic_rst set", logic_rst, 1);
        check(comm_rst == 0, "R6 comm_rst untouched", comm_rst, 0);
        // R6 comm reset commands
        send(8'hFE); send(8'h87);
        check(comm_rst == 1, "R6 comm_rst set", comm_rst, 1);
        send(8'hFE); send(8'h81);
        check(logic_rst == 0, "R5 logic_rst clear", logic_rst, 0);
        check(comm_rst == 1, "R6 comm_rst held", comm_rst, 1);
        send(8'hFE); send(8'h85);
        check(comm_rst == 0, "R6 comm_rst clear", comm_rst, 0);

        // R7 unknown control words
        send(8'hFE); send(8'hF1);
        send(8'hFE); send(8'h80);
        check(logic_rst == 0 && comm_rst == 0, "R7 resets unchanged",
              {logic_rst, comm_rst}, 0);
        send_data(8'h77);
        drain();

        // R8 / R9 stall: held byte, dropped byte, command still decoded
        out_ready = 1'b0;
        send_data(8'hA5);
        send(8'h3C);
        send(8'hFE); send(8'h83);
        check(logic_rst == 1, "R8 command during stall", logic_rst, 1);
        check(out_valid == 1, "R8 valid held", out_valid, 1);
        check(out_data == 8'hA5, "R9 held byte kept", out_data, 8'hA5);
        out_ready = 1'b1;
        drain();
        send(8'hFE); send(8'h81);

        // Same cycle: credit pulse visible while the held byte is handed off
        out_ready = 1'b0;
        send_data(8'h5A);
        exp_cred.push_back(14'h0ABC);
        send(8'hFE); send({1'b0, 6'h0A, 1'b1});
        send(8'hBC);
        check(credit_valid == 1 && out_valid == 1, "R4 credit with held byte",
              {credit_valid, out_valid}, 3);
        cnt_before = data_count;
        out_ready = 1'b1;
        @(posedge clk); #1;
        check(data_count == cnt_before + 1'b1, "R10 count step", data_count, cnt_before + 1'b1);

        // R10 wrap of the modulo counter
        for (int i = 0; i < 8; i++) send_data(8'(i * 3 + 1));
        drain();
        repeat (2) @(posedge clk);
        #1;
        check(data_count == CNT_W'(total), "R10 count modulo", data_count, CNT_W'(total));
        check(exp_data.size() == 0, "R2 all data seen", exp_data.size(), 0);
        check(exp_cred.size() == 0, "R4 all credits seen", exp_cred.size(), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule